// File: doc/BRIEF.md
# Third-Order Sinc Up-Sampling Interpolator

This block sits between a host serial port and a digital sigma-delta modulator on the playback path. The host writes 16-bit two's-complement samples at a slow input rate. The block raises them to the modulator rate with a third-order sinc (cascaded comb/integrator) interpolator, whose transfer function is ((1 - z^-N)/(1 - z^-1))^3. The up-sampling factor N is 32, 64, 128 or 256, chosen by a 2-bit rate select. The output advances once per modulator tick. One input sample is taken every N ticks, so the input rate is 1/N of the tick rate.

Samples go into a holding register, and each input slot reads that register. If the host misses a slot, the previous value is filtered again. If it writes more than once between slots, only the last value counts. A bypass control skips the filter: the held sample appears at every tick with the least possible delay. Any change of rate select or bypass clears the filter. In filter mode the output then reads zero until the history holds enough real samples.

Top module: `sinc3_interp`

## Requirements
- R1: While reset is high, and directly after it, `out_valid` is low and `out_data` is 0x0000.
- R2: `out_valid` is high for exactly one clock after each clock in which `mod_tick` was high, except in a clock where the configuration changes.
- R3: Rate select code 0, 1, 2, 3 selects N = 32, 64, 128, 256. After a configuration change into filter mode, the output is forced to zero for exactly 3N+1 outputs. These run up to and including the output of the tick that takes the fourth input sample. The next output is non-zero for a held sample of magnitude at least 0x1000.
- R4: In filter mode, once one sample value has been taken at four consecutive input slots, every following output equals that value exactly, at every rate. DC gain is N^2, removed by an arithmetic right shift of 2*log2(N).
- R5: When the host writes nothing, each input slot reuses the previously held sample, so a settled output stays at that value indefinitely.
- R6: Several writes between two input slots leave only the most recent one in effect.
- R7: After a step from settled value A to value B, every output lies between A and B inclusive (signed), and the output then settles to exactly B.
- R8: Positive full scale 0x7FFF and negative full scale 0x8000 pass through the settled filter without change.
- R9: In bypass mode, each output equals the held sample. A write becomes visible at the first tick after the clock in which it is registered.
- R10: A change of `rate_sel` or `bypass` clears all filter state and drives `out_data` to 0x0000 in the following clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_data | input | 16 | Sample from host, two's complement |
| host_wr | input | 1 | Write strobe for `host_data` into the holding register |
| rate_sel | input | 2 | Up-sampling factor select (0:N=32, 1:64, 2:128, 3:256) |
| bypass | input | 1 | 1 = skip the filter and present the held sample |
| mod_tick | input | 1 | One-clock pulse at the modulator (output) rate |
| out_data | output | 16 | Output sample, two's complement |
| out_valid | output | 1 | Pulses one clock after each accepted tick |

## Verification
The bench goes after the priming window after each rate change. An interpolator that counted slots wrongly, or decoded the rate select wrongly, would release its first non-zero output at a tick other than 3N+2. It runs DC settling at all four rates with both full-scale codes, where a wrong normalising shift or a missing saturation would scale the result. Random steps must stay inside the band between the two levels: an integrator wired out of order or a comb with a bad delay would overshoot. Long runs with no host writes and bursts of back-to-back writes expose a holding register that drops to zero or keeps the first write. Bypass checks compare every output bit for bit with the last written value.

// File: rtl/sinc3_interp_pkg.sv
package sinc3_interp_pkg;

    // Up-sampling factor selection; encoding is the rate select input.
    typedef enum logic [1:0] {
        RATE_N32  = 2'd0,
        RATE_N64  = 2'd1,
        RATE_N128 = 2'd2,
        RATE_N256 = 2'd3
    } rate_e;

    // Configuration word; any change restarts the filter.
    typedef struct packed {
        rate_e rate;
        logic  bypass;
    } cfg_t;

    // log2 of the up-sampling factor for a rate code.
    function automatic int unsigned rate_log2n(input rate_e r, input int unsigned base);
        return base + int'(r);
    endfunction

endpackage

// File: rtl/interp_slot_timer.sv
module interp_slot_timer #(
    parameter int PH_W        = 8,
    parameter int L2_W        = 4,
    parameter int PRIME_SLOTS = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            clr,
    input  logic            tick,
    input  logic [L2_W-1:0] log2n,
    output logic            slot,
    output logic            primed
);
    localparam int CNT_W = $clog2(PRIME_SLOTS + 1);

    logic [PH_W-1:0]  phase_q;
    logic [CNT_W-1:0] cnt_q;
    logic [PH_W:0]    last_phase;

    assign last_phase = ({{PH_W{1'b0}}, 1'b1} << log2n) - 1'b1;
    assign slot       = tick && (phase_q == '0) && !clr;
    assign primed     = (cnt_q == CNT_W'(PRIME_SLOTS));

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            phase_q <= '0;
            cnt_q   <= '0;
        end else if (tick) begin
            if ({1'b0, phase_q} == last_phase) begin
                phase_q <= '0;
            end else begin
                phase_q <= phase_q + 1'b1;
            end
            if (slot && !primed) begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    // R3: phase never passes N-1 for the active rate
    a_r3_phase_bound: assert property (@(posedge clk) disable iff (rst)
        !clr |-> ({1'b0, phase_q} <= last_phase));

    // R10: a clear always restarts the priming count
    a_r10_unprimed_after_clear: assert property (@(posedge clk) disable iff (rst)
        clr |=> !primed);

endmodule

// File: rtl/interp_comb.sv
module interp_comb #(
    parameter int W = 19
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                clr,
    input  logic                en,
    input  logic signed [W-1:0] din,
    output logic signed [W-1:0] dout
);
    logic signed [W-1:0] dly_q;

    assign dout = din - dly_q;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            dly_q <= '0;
        end else if (en) begin
            dly_q <= din;
        end
    end
endmodule

// File: rtl/interp_integ.sv
module interp_integ #(
    parameter int W = 35
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                clr,
    input  logic                en,
    input  logic signed [W-1:0] din,
    output logic signed [W-1:0] acc
);
    always_ff @(posedge clk) begin
        if (rst || clr) begin
            acc <= '0;
        end else if (en) begin
            acc <= acc + din;
        end
    end
endmodule

// File: rtl/sinc3_interp.sv
module sinc3_interp
    import sinc3_interp_pkg::*;
#(
    parameter int DATA_W      = 16,
    parameter int ORDER       = 3,
    parameter int LOG2_NMIN   = 5,
    parameter int LOG2_NMAX   = 8,
    parameter int PRIME_SLOTS = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] host_data,
    input  logic              host_wr,
    input  logic [1:0]        rate_sel,
    input  logic              bypass,
    input  logic              mod_tick,
    output logic [DATA_W-1:0] out_data,
    output logic              out_valid
);
    localparam int CW   = DATA_W + ORDER;
    localparam int AW   = DATA_W + ORDER + (ORDER - 1) * LOG2_NMAX;
    localparam int L2_W = $clog2(LOG2_NMAX + 1);
    localparam int SH_W = $clog2((ORDER - 1) * LOG2_NMAX + 1);
    localparam logic signed [AW-1:0] SAT_HI = {{(AW-DATA_W+1){1'b0}}, {(DATA_W-1){1'b1}}};
    localparam logic signed [AW-1:0] SAT_LO = {{(AW-DATA_W+1){1'b1}}, {(DATA_W-1){1'b0}}};

    cfg_t               cfg_in, cfg_q;
    logic               clr;
    logic [DATA_W-1:0]  hold_q;
    logic [L2_W-1:0]    log2n;
    logic [SH_W-1:0]    shift_amt;
    logic               slot, primed;
    logic signed [AW-1:0] scaled;
    logic [DATA_W-1:0]  sat_val;

    logic signed [CW-1:0] comb_in  [ORDER];
    logic signed [CW-1:0] comb_out [ORDER];
    logic signed [AW-1:0] integ_in [ORDER];
    logic signed [AW-1:0] integ_acc[ORDER];

    assign cfg_in    = '{rate: rate_e'(rate_sel), bypass: bypass};
    assign clr       = (cfg_in != cfg_q);
    assign log2n     = L2_W'(rate_log2n(cfg_q.rate, LOG2_NMIN));
    assign shift_amt = SH_W'((ORDER - 1) * int'(log2n));

    interp_slot_timer #(
        .PH_W        (LOG2_NMAX),
        .L2_W        (L2_W),
        .PRIME_SLOTS (PRIME_SLOTS)
    ) u_timer (
        .clk    (clk),
        .rst    (rst),
        .clr    (clr),
        .tick   (mod_tick),
        .log2n  (log2n),
        .slot   (slot),
        .primed (primed)
    );

    // Combs run once per input slot on the held sample.
    assign comb_in[0] = {{(CW-DATA_W){hold_q[DATA_W-1]}}, hold_q};

    for (genvar k = 0; k < ORDER; k++) begin : g_comb
        interp_comb #(.W(CW)) u_comb (
            .clk  (clk),
            .rst  (rst),
            .clr  (clr),
            .en   (slot),
            .din  (comb_in[k]),
            .dout (comb_out[k])
        );
        if (k < ORDER - 1) begin : g_link
            assign comb_in[k+1] = comb_out[k];
        end
    end

    // Zero-stuffing: the comb result enters only at slot ticks.
    assign integ_in[0] = slot ? {{(AW-CW){comb_out[ORDER-1][CW-1]}}, comb_out[ORDER-1]} : '0;

    for (genvar k = 0; k < ORDER; k++) begin : g_integ
        interp_integ #(.W(AW)) u_integ (
            .clk  (clk),
            .rst  (rst),
            .clr  (clr),
            .en   (mod_tick),
            .din  (integ_in[k]),
            .acc  (integ_acc[k])
        );
        if (k < ORDER - 1) begin : g_link
            assign integ_in[k+1] = integ_acc[k];
        end
    end

    assign scaled = integ_acc[ORDER-1] >>> shift_amt;

    always_comb begin
        if (scaled > SAT_HI) begin
            sat_val = SAT_HI[DATA_W-1:0];
        end else if (scaled < SAT_LO) begin
            sat_val = SAT_LO[DATA_W-1:0];
        end else begin
            sat_val = scaled[DATA_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q     <= cfg_in;
            hold_q    <= '0;
            out_data  <= '0;
            out_valid <= 1'b0;
        end else begin
            cfg_q <= cfg_in;
            if (host_wr) begin
                hold_q <= host_data;
            end
            if (clr) begin
                out_valid <= 1'b0;
                out_data  <= '0;
            end else begin
                out_valid <= mod_tick;
                if (mod_tick) begin
                    if (cfg_q.bypass) begin
                        out_data <= hold_q;
                    end else if (primed) begin
                        out_data <= sat_val;
                    end else begin
                        out_data <= '0;
                    end
                end
            end
        end
    end

    // R2: a valid output only ever follows a tick
    a_r2_valid_after_tick: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(mod_tick));

    // R5: the held sample changes only on a write
    a_r5_hold_stable: assert property (@(posedge clk) disable iff (rst)
        !host_wr |=> $stable(hold_q));

    // R9: bypass output is the held sample of the tick clock
    a_r9_bypass_exact: assert property (@(posedge clk) disable iff (rst)
        (out_valid && $past(cfg_q.bypass) && !$past(clr)) |-> (out_data == $past(hold_q)));

    // R10: a configuration change zeroes the output next clock
    a_r10_clear_zero: assert property (@(posedge clk) disable iff (rst)
        clr |=> (out_data == '0 && !out_valid));

endmodule

// File: tb/sinc3_interp_tb.sv
module sinc3_interp_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] host_data = '0;
    logic        host_wr = 1'b0;
    logic [1:0]  rate_sel = 2'd3;
    logic        bypass = 1'b0;
    logic        mod_tick = 1'b0;
    logic        tick_seen = 1'b0;
    logic [15:0] out_data;
    logic        out_valid;
    int          tick_cnt = 0;
    int          n_checks = 0;
    int          n_fail = 0;
    bit          done = 1'b0;

    always #5 clk = ~clk;

    // Tick every fourth clock, updated at the edge so the DUT sees a stable value.
    always @(posedge clk) begin
        tick_cnt  <= (tick_cnt == 3) ? 0 : tick_cnt + 1;
        mod_tick  <= (tick_cnt == 3);
        tick_seen <= mod_tick;
    end

    sinc3_interp u_dut (
        .clk       (clk),
        .rst       (rst),
        .host_data (host_data),
        .host_wr   (host_wr),
        .rate_sel  (rate_sel),
        .bypass    (bypass),
        .mod_tick  (mod_tick),
        .out_data  (out_data),
        .out_valid (out_valid)
    );

    function automatic int n_of(input int r);
        return 32 << r;
    endfunction

    function automatic logic [15:0] rand_big();
        logic [15:0] m;
        m = 16'h1000 + 16'($urandom % 32'h6000);
        return ($urandom % 2) ? m : -m;
    endfunction

    function automatic bit in_band(input logic [15:0] d, input logic [15:0] a, input logic [15:0] b);
        logic signed [15:0] lo, hi;
        lo = ($signed(a) < $signed(b)) ? a : b;
        hi = ($signed(a) < $signed(b)) ? b : a;
        return ($signed(d) >= lo) && ($signed(d) <= hi);
    endfunction

    task automatic check(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic next_out(output logic [15:0] d);
        do @(negedge clk); while (!out_valid);
        d = out_data;
    endtask

    task automatic skip_out(input int k);
        logic [15:0] t;
        repeat (k) next_out(t);
    endtask

    task automatic host_write(input logic [15:0] v);
        @(negedge clk);
        host_data = v;
        host_wr   = 1'b1;
        @(negedge clk);
        host_wr   = 1'b0;
    endtask

    task automatic set_cfg(input int r, input bit b);
        @(negedge clk);
        rate_sel = 2'(r);
        bypass   = b;
    endtask

    task automatic expect_const(input logic [15:0] v, input int k, input string req);
        logic [15:0] d, bad;
        bit ok;
        ok  = 1'b1;
        bad = v;
        for (int i = 0; i < k; i++) begin
            next_out(d);
            if (ok && d != v) begin
                ok  = 1'b0;
                bad = d;
            end
        end
        check(ok, req, bad, v);
    endtask

    initial begin
        logic [15:0] v, a, b, c, d, bad;
        int          zeros;
        bit          ok;
        void'($urandom(32'd20240611));

        // R1: reset state
        repeat (3) @(negedge clk);
        check(!out_valid && out_data == 16'h0, "R1", out_data, 16'h0);
        rst = 1'b0;
        @(negedge clk);
        check(!out_valid && out_data == 16'h0, "R1", out_data, 16'h0);

        // R2: valid follows tick by one clock
        ok = 1'b1;
        repeat (40) begin
            @(negedge clk);
            if (out_valid != tick_seen) ok = 1'b0;
        end
        check(ok, "R2", {15'h0, out_valid}, {15'h0, tick_seen});

        // R3, R10, R4: every rate, priming window then DC
        for (int r = 0; r < 4; r++) begin
            v = rand_big();
            host_write(v);
            set_cfg(r, 1'b0);
            zeros = 0;
            do begin
                next_out(d);
                if (d == 16'h0) zeros++;
            end while (d == 16'h0 && zeros < 4 * n_of(r));
            check(zeros >= 3 * n_of(r), "R10", 16'(zeros), 16'(3 * n_of(r)));
            check(zeros == 3 * n_of(r) + 1, "R3", 16'(zeros), 16'(3 * n_of(r) + 1));
            skip_out(3 * n_of(r));
            expect_const(v, n_of(r), "R4");
        end

        // R5: hold with no writes at N=32
        set_cfg(0, 1'b0);
        v = rand_big();
        host_write(v);
        skip_out(6 * 32);
        expect_const(v, 12 * 32, "R5");

        // R6: burst of writes between slots, last one wins
        next_out(d);
        a = rand_big();
        b = rand_big();
        c = rand_big();
        @(negedge clk); host_data = a; host_wr = 1'b1;
        @(negedge clk); host_data = b;
        @(negedge clk); host_data = c;
        @(negedge clk); host_wr = 1'b0;
        skip_out(6 * 32);
        expect_const(c, 2 * 32, "R6");

        // R7: random steps stay within band and settle
        a = c;
        for (int s = 0; s < 6; s++) begin
            b = 16'($urandom);
            host_write(b);
            ok  = 1'b1;
            bad = b;
            for (int i = 0; i < 6 * 32; i++) begin
                next_out(d);
                if (ok && !in_band(d, a, b)) begin
                    ok  = 1'b0;
                    bad = d;
                end
            end
            check(ok, "R7", bad, b);
            expect_const(b, 32, "R7");
            a = b;
        end

        // R8: full scale both ways, including a full-range step
        host_write(16'h7FFF);
        skip_out(6 * 32);
        expect_const(16'h7FFF, 32, "R8");
        host_write(16'h8000);
        ok  = 1'b1;
        bad = 16'h8000;
        for (int i = 0; i < 6 * 32; i++) begin
            next_out(d);
            if (ok && !in_band(d, 16'h7FFF, 16'h8000)) begin
                ok  = 1'b0;
                bad = d;
            end
        end
        check(ok, "R7", bad, 16'h8000);
        expect_const(16'h8000, 32, "R8");

        // R9: bypass path, bit exact
        set_cfg(0, 1'b1);
        for (int i = 0; i < 20; i++) begin
            v = 16'($urandom);
            if (i == 3) v = 16'h7FFF;
            if (i == 4) v = 16'h8000;
            host_write(v);
            expect_const(v, 3, "R9");
        end

        // R10: leaving bypass clears and re-primes
        v = rand_big();
        host_write(v);
        set_cfg(0, 1'b0);
        expect_const(16'h0, 3 * 32, "R10");
        skip_out(3 * 32 + 2);
        expect_const(v, 32, "R4");

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end
endmodule